// File: doc/BRIEF.md
# Trigger Frequency Rescaler

This block turns an external line-trigger train into a second pulse train whose rate is the input rate times M and divided by D. One of two trigger lines is chosen as the source. The time between successive rising edges on that line is measured with a saturating counter. That counter advances on a tick that is the base clock divided by 1, 4, 16 or 64, as set by a two-bit granularity code. Each measured period, multiplied by D, becomes the threshold of a phase accumulator. The accumulator gains M on every tick and emits one output pulse each time it passes the threshold, keeping the remainder. Over any D input periods it therefore delivers M output pulses, and fractional spacing does not drift.

The block has no stream interfaces. Triggers, configuration and status are plain pins, and trigger inputs are expected to be synchronous to the clock already. A bypass mode forwards each rising edge of the selected line as a single pulse. Setting M or D to zero also selects bypass. If the counter saturates, an overflow flag rises and generated pulses stop. They restart once a full period has been measured in range. Software should pick the finest granularity whose full counter range still exceeds the trigger period.

Top module: `trig_rescaler`

## Requirements
- R1: After reset, trig_out, rate_locked and period_ovf are 0 and meas_period is 0.
- R2: The configuration word fields are: bit 0 is the source select (0 = trig_line0, 1 = trig_line1), bit 1 is bypass, bits [17:6] are the divider D, bits [29:18] are the multiplier M, and bits [31:30] are the granularity code.
- R3: In bypass (bit 1 set, or M = 0, or D = 0), each rising edge on the selected line gives a one-cycle trig_out pulse on the clock after the edge is sampled.
- R4: meas_period is loaded at each rising edge of the selected line, except the first after reset. Its value is floor(cycles since the previous edge / 4^code) and it holds between edges. rate_locked rises at the second edge.
- R5: When locked and not in bypass, trig_out gives M pulses per D input periods. Any window of whole input periods carries the ideal count to within one pulse.
- R6: Every trig_out pulse lasts one clock cycle and is followed by at least one low cycle while the configuration is unchanged.
- R7: If the period counter reaches its all-ones value without an edge, period_ovf rises, rate_locked falls and no generated pulses appear. Both flags are recovered only by the first edge that closes an in-range period.
- R8: Granularity code c divides the tick by 4^c, so a period too long for code 0 is measured without overflow at a coarser code.
- R9: Edges on the unselected trigger line have no effect on trig_out or meas_period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (20 ns) |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_line0 | input | 1 | Trigger line 0 |
| trig_line1 | input | 1 | Trigger line 1 |
| cfg_word | input | 32 | Configuration word (fields in R2) |
| trig_out | output | 1 | Rescaled or bypassed trigger pulse |
| rate_locked | output | 1 | A valid period is held and generation is active |
| period_ovf | output | 1 | The last period exceeded the counter range |
| meas_period | output | CNT_W | Last measured period in ticks |

## Verification
In bypass, a pulse is due exactly one clock after the cycle in which the bench raises the selected line. The bench raises lines just after a falling edge and checks trig_out at the next falling edge. meas_period, rate_locked and period_ovf are registered on the edge cycle, or on the cycle the counter saturates. They are read only after at least one further falling edge. Generated pulses are counted over windows that start and end in the same phase of the input period, after three warm-up periods, and each count is compared with M per D periods within one pulse.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int CFG_W  = 32;
  localparam int MD_W   = 12;
  localparam int GRAN_W = 2;

  typedef struct packed {
    logic [GRAN_W-1:0] gran;
    logic [MD_W-1:0]   mult;
    logic [MD_W-1:0]   divr;
    logic              bypass;
    logic              sel;
  } trs_cfg_t;

  function automatic trs_cfg_t trs_decode(input logic [CFG_W-1:0] w);
    trs_cfg_t c;
    c.gran   = w[31:30];
    c.mult   = w[29:18];
    c.divr   = w[17:6];
    c.bypass = w[1];
    c.sel    = w[0];
    return c;
  endfunction
endpackage

// File: rtl/trs_edge_pick.sv
module trs_edge_pick #(
  parameter int N_LINES = 2,
  localparam int SEL_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               edge_o
);
  logic [N_LINES-1:0] prev_q;
  logic [N_LINES-1:0] rise;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lines_i;
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_rise
    assign rise[i] = lines_i[i] & ~prev_q[i];
  end

  always_comb begin
    edge_o = 1'b0;
    for (int i = 0; i < N_LINES; i++)
      if (SEL_W'(i) == sel_i) edge_o = rise[i];
  end
endmodule

// File: rtl/trs_period_meter.sv
module trs_period_meter #(
  parameter int CNT_W    = 16,
  parameter int PRE_BASE = 1,
  parameter int GRAN_W   = 2,
  localparam int MAX_PRE = PRE_BASE << (2 * ((1 << GRAN_W) - 1)),
  localparam int DIV_W   = $clog2(MAX_PRE) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_i,
  input  logic [GRAN_W-1:0] gran_i,
  output logic              tick_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  period_o,
  output logic              locked_o,
  output logic              ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DIV_W-1:0] pre_n, div_q;
  logic [CNT_W-1:0] cnt_q, cnt_now, period_q;
  logic             seen_q, locked_q, ovf_q;
  logic             in_range;

  always_comb begin
    pre_n  = DIV_W'(PRE_BASE) << {gran_i, 1'b0};
    tick_o = (div_q >= pre_n - DIV_W'(1));
    if (tick_o && cnt_q != CNT_MAX) cnt_now = cnt_q + CNT_W'(1);
    else                            cnt_now = cnt_q;
    in_range = (cnt_now != '0) && (cnt_now != CNT_MAX);
    load_o   = edge_i && seen_q && in_range;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= '0;
      cnt_q    <= '0;
      period_q <= '0;
      seen_q   <= 1'b0;
      locked_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else if (edge_i) begin
      div_q  <= '0;
      cnt_q  <= '0;
      seen_q <= 1'b1;
      if (seen_q) begin
        period_q <= cnt_now;
        ovf_q    <= (cnt_now == CNT_MAX);
        locked_q <= in_range;
      end
    end else begin
      div_q <= tick_o ? '0 : div_q + DIV_W'(1);
      cnt_q <= cnt_now;
      if (seen_q && cnt_now == CNT_MAX) begin
        ovf_q    <= 1'b1;
        locked_q <= 1'b0;
      end
    end
  end

  assign period_o = period_q;
  assign locked_o = locked_q;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/trs_pulse_gen.sv
module trs_pulse_gen #(
  parameter int CNT_W = 16,
  parameter int MD_W  = 12,
  localparam int THR_W = CNT_W + MD_W,
  localparam int ACC_W = THR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             locked_i,
  input  logic             hold_i,
  input  logic             last_pulse_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [MD_W-1:0]  mult_i,
  input  logic [MD_W-1:0]  div_i,
  output logic             fire_o
);
  logic [THR_W-1:0] thr_q;
  logic [ACC_W-1:0] acc_q, acc_sum, acc_d;

  always_comb begin
    fire_o = locked_i && !hold_i && !last_pulse_i && (thr_q != '0) &&
             (acc_q >= ACC_W'(thr_q));
    acc_sum = acc_q + (tick_i ? ACC_W'(mult_i) : '0);
    if (hold_i || !locked_i) acc_d = '0;
    else                     acc_d = acc_sum - (fire_o ? ACC_W'(thr_q) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= '0;
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
      if (load_i) thr_q <= THR_W'(period_i) * THR_W'(div_i);
    end
  end
endmodule

// File: rtl/trig_rescaler.sv
module trig_rescaler #(
  parameter int CNT_W    = 16,
  parameter int PRE_BASE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_line0,
  input  logic             trig_line1,
  input  logic [31:0]      cfg_word,
  output logic             trig_out,
  output logic             rate_locked,
  output logic             period_ovf,
  output logic [CNT_W-1:0] meas_period
);
  import trs_pkg::*;

  trs_cfg_t   cfg;
  logic       bypass_eff, sel_edge, tick, load, fire, out_q;

  always_comb begin
    cfg        = trs_decode(cfg_word);
    bypass_eff = cfg.bypass || (cfg.mult == '0) || (cfg.divr == '0);
  end

  trs_edge_pick #(.N_LINES(2)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .lines_i({trig_line1, trig_line0}),
    .sel_i(cfg.sel),
    .edge_o(sel_edge)
  );

  trs_period_meter #(.CNT_W(CNT_W), .PRE_BASE(PRE_BASE), .GRAN_W(GRAN_W)) u_meter (
    .clk(clk), .rst_n(rst_n),
    .edge_i(sel_edge), .gran_i(cfg.gran),
    .tick_o(tick), .load_o(load),
    .period_o(meas_period), .locked_o(rate_locked), .ovf_o(period_ovf)
  );

  trs_pulse_gen #(.CNT_W(CNT_W), .MD_W(MD_W)) u_gen (
    .clk(clk), .rst_n(rst_n),
    .tick_i(tick), .load_i(load), .locked_i(rate_locked),
    .hold_i(bypass_eff), .last_pulse_i(out_q),
    .period_i(meas_period), .mult_i(cfg.mult), .div_i(cfg.divr),
    .fire_o(fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= bypass_eff ? sel_edge : fire;
  end

  assign trig_out = out_q;
endmodule

// File: rtl/trs_checker.sv
module trs_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_line0,
  input logic             trig_line1,
  input logic [31:0]      cfg_word,
  input logic             trig_out,
  input logic             rate_locked,
  input logic             period_ovf,
  input logic [CNT_W-1:0] meas_period
);
  logic [1:0] prev_q;
  logic       byp_eff, sel_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= {trig_line1, trig_line0};
  end

  always_comb begin
    byp_eff  = cfg_word[1] || (cfg_word[29:18] == '0) || (cfg_word[17:6] == '0);
    sel_edge = cfg_word[0] ? (trig_line1 && !prev_q[1]) : (trig_line0 && !prev_q[0]);
  end

  assert_bypass_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_eff && sel_edge) |=> trig_out);

  assert_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> (!trig_out || cfg_word != $past(cfg_word)));

  assert_quiet_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_locked && !byp_eff) |=> !trig_out);

  assert_ovf_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    period_ovf |-> !rate_locked);

  assert_period_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_edge |=> $stable(meas_period));
endmodule

bind trig_rescaler trs_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_trig_rescaler.sv
module sim_trig_rescaler;
  localparam int CLK_PERIOD = 20;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig_line0 = 1'b0;
  logic          trig_line1 = 1'b0;
  logic [31:0]   cfg_word = '0;
  logic          trig_out, rate_locked, period_ovf;
  logic [CW-1:0] meas_period;

  int errors = 0;
  int checks = 0;
  int pulse_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_rescaler #(.CNT_W(CW), .PRE_BASE(1)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_line0(trig_line0), .trig_line1(trig_line1),
    .cfg_word(cfg_word), .trig_out(trig_out), .rate_locked(rate_locked),
    .period_ovf(period_ovf), .meas_period(meas_period)
  );

  always @(posedge clk) if (rst_n && trig_out) pulse_cnt++;

  function automatic logic [31:0] mk_cfg(int gran, int m, int d, bit byp, bit sel);
    return {gran[1:0], m[11:0], d[11:0], 4'b0, byp, sel};
  endfunction

  function automatic int exp_ticks(int cycles, int gran);
    return cycles / (1 << (2 * gran));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_near(string req, int act, int exp);
    checks++;
    if (act > exp + 1 || act < exp - 1) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (+-1)", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // One rising edge on a line, then wait so that edges lie pc cycles apart.
  task automatic trig_period(bit line, int pc);
    if (line) trig_line1 = 1'b1; else trig_line0 = 1'b1;
    @(negedge clk);
    trig_line0 = 1'b0;
    trig_line1 = 1'b0;
    repeat (pc - 1) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    int base;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 trig_out", int'(trig_out), 0);
    chk("R1 rate_locked", int'(rate_locked), 0);
    chk("R1 period_ovf", int'(period_ovf), 0);
    chk("R1 meas_period", int'(meas_period), 0);

    // R3 bypass on line 0
    cfg_word = mk_cfg(0, 3, 2, 1'b1, 1'b0);
    @(negedge clk);
    trig_line0 = 1'b1;
    @(negedge clk);
    chk("R3 bypass pulse", int'(trig_out), 1);
    trig_line0 = 1'b0;
    @(negedge clk);
    chk("R6 bypass width", int'(trig_out), 0);
    // R9 unselected line ignored
    base = pulse_cnt;
    trig_line1 = 1'b1;
    @(negedge clk);
    chk("R9 unselected line trig_out", int'(trig_out), 0);
    trig_line1 = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 unselected line pulses", pulse_cnt - base, 0);
    // R3 with M = 0 and select line 1
    cfg_word = mk_cfg(0, 0, 2, 1'b0, 1'b1);
    @(negedge clk);
    trig_line1 = 1'b1;
    @(negedge clk);
    chk("R3 M=0 acts as bypass", int'(trig_out), 1);
    trig_line1 = 1'b0;
    @(negedge clk);

    // R4 R5 directed: M=3, D=2, period 120 on line 0
    cfg_word = mk_cfg(0, 3, 2, 1'b0, 1'b0);
    trig_period(0, 120);
    trig_period(0, 120);
    chk("R4 locked after second edge", int'(rate_locked), 1);
    chk("R4 measured period", int'(meas_period), 120);
    trig_period(0, 120);
    base = pulse_cnt;
    repeat (4) trig_period(0, 120);
    chk_near("R5 pulses M=3 D=2 over 4 periods", pulse_cnt - base, 6);
    // R9 line 1 edges do not disturb meas_period
    trig_line1 = 1'b1;
    @(negedge clk);
    trig_line1 = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 meas_period unchanged", int'(meas_period), 120);

    // R5 R2 constrained random
    for (int t = 0; t < 12; t++) begin
      int m, d, pc;
      m  = 1 + int'($urandom % 8);
      d  = 1 + int'($urandom % 4);
      pc = 40 + int'($urandom % 261);
      cfg_word = mk_cfg(0, m, d, 1'b0, 1'b0);
      repeat (3) trig_period(0, pc);
      chk("R4 random measured period", int'(meas_period), exp_ticks(pc, 0));
      base = pulse_cnt;
      repeat (2 * d) trig_period(0, pc);
      chk_near("R5 random pulse count", pulse_cnt - base, 2 * m);
    end

    // R7 overflow and recovery
    cfg_word = mk_cfg(0, 2, 1, 1'b0, 1'b0);
    repeat (3) trig_period(0, 200);
    trig_period(0, 1000);
    base = pulse_cnt;
    repeat (200) @(negedge clk);
    chk("R7 overflow flag", int'(period_ovf), 1);
    chk("R7 unlocked on overflow", int'(rate_locked), 0);
    chk("R7 no pulses in overflow", pulse_cnt - base, 0);
    trig_period(0, 200);
    chk("R7 saturated period keeps overflow", int'(period_ovf), 1);
    trig_period(0, 200);
    chk("R7 overflow cleared", int'(period_ovf), 0);
    chk("R7 relocked", int'(rate_locked), 1);

    // R8 coarser granularity measures a long period
    cfg_word = mk_cfg(1, 4, 1, 1'b0, 1'b0);
    repeat (3) trig_period(0, 1200);
    chk("R8 code 1 measured period", int'(meas_period), exp_ticks(1200, 1));
    chk("R8 code 1 no overflow", int'(period_ovf), 0);
    base = pulse_cnt;
    repeat (2) trig_period(0, 1200);
    chk_near("R8 code 1 pulse count", pulse_cnt - base, 8);
    cfg_word = mk_cfg(2, 4, 1, 1'b0, 1'b0);
    repeat (2) trig_period(0, 1200);
    chk("R8 code 2 measured period", int'(meas_period), exp_ticks(1200, 2));

    done = 1;
    summary();
    $finish;
  end
endmodule